// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Aligner

This block sits between instruction fetch and decode. It takes a stream of 16-bit instruction parcels in program order over a valid/ready handshake. The first parcel of each instruction carries a prefix code in its low bits. The block reads that code to learn how many parcels the instruction spans, which is between 1 and 12. It collects that many parcels and presents the whole instruction at once, left-aligned in a 192-bit word. The word comes with the parcel count, a length class, the destination-register field of the longest format, and an illegal flag.

A prefix the block cannot accept produces a one-parcel output with the illegal flag set, so the stream keeps moving. There are two such cases: the longest format with its top bit set, and a 16-bit instruction while 16-bit instructions are disabled. A synchronous flush throws away any half-gathered instruction and any result that has not been taken yet.

Top module: `parcel_aligner`

## Requirements
- R1: If bits [1:0] of a first parcel are 00, 01 or 10, the instruction is one parcel long and reports class code 0.
- R2: If bits [1:0] are 11 and bits [4:2] are not 111, the instruction is two parcels long and reports class code 1.
- R3: If bits [5:0] equal 011111, the instruction is three parcels long and reports class code 2.
- R4: If bits [6:0] equal 0111111, the instruction is four parcels long and reports class code 3.
- R5: If bits [6:0] equal 1111111, the instruction is 5 + n parcels long, where n is bits [14:12]. It reports class code 4, and `out_rd` carries bits [11:7] of the first parcel. For every other class `out_rd` is zero.
- R6: If the first parcel is in the class-4 format and its bit 15 is 1, the block emits that parcel alone. The output then has `out_illegal` = 1, class code 4 and a parcel count of 1.
- R7: While `allow_short` is 0, a first parcel whose bits [1:0] are not 11 is emitted alone with `out_illegal` = 1 and class code 0.
- R8: The first parcel sits in bits [15:0] of `out_insn`, and each following parcel fills the next 16 bits up. All bits above the last parcel are zero.
- R9: Once `out_valid` is high, it stays high with `out_insn` unchanged until a cycle in which `out_ready` is high. While `out_valid` is high and `out_ready` is low, `in_ready` is low.
- R10: While `flush` is high at a clock edge, the block drops any partly gathered instruction and any pending output. `out_valid` is low in the next cycle, and the next accepted parcel is treated as a first parcel.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard partial and pending work |
| allow_short | input | 1 | 1 = 16-bit instructions permitted |
| in_valid | input | 1 | Parcel present |
| in_parcel | input | 16 | Instruction parcel |
| in_ready | output | 1 | Parcel will be taken |
| out_valid | output | 1 | Complete instruction present |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 192 | Left-aligned instruction, upper bits zero |
| out_parcels | output | 4 | Parcel count, 1 to 12 |
| out_class | output | 3 | Length class code, 0 to 4 |
| out_rd | output | 5 | Destination field of the class-4 format |
| out_illegal | output | 1 | Reserved or disabled length |

## Verification
The result is due one cycle after the clock edge that accepts the last parcel of an instruction. For a single-parcel instruction, that is the edge that accepts its first parcel. The result then holds until the edge at which `out_ready` is high.

The bench changes its inputs at the falling edge. It evaluates both handshakes just before the next rising edge, and that rising edge is where the transfer happens. Each output the design delivers is compared with the head of a queue of expected instructions, which is built from the prefix rules. A stalled output is checked again one cycle later to confirm it is still there and unchanged.

After a flush, `out_valid` is checked on the very next cycle. Any later output that has no matching queued entry is reported as a failure.

// File: rtl/parcel_aligner.sv
module parcel_aligner (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         allow_short,
  input  logic         in_valid,
  input  logic [15:0]  in_parcel,
  output logic         in_ready,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [191:0] out_insn,
  output logic [3:0]   out_parcels,
  output logic [2:0]   out_class,
  output logic [4:0]   out_rd,
  output logic         out_illegal
);
  localparam int PW   = 16;
  localparam int MAXP = 12;
  localparam int OW   = PW * MAXP;
  localparam int CW   = $clog2(MAXP + 1);

  logic [OW-1:0] buf_q;
  logic [CW-1:0] cnt_q, need_q;
  logic [2:0]    cls_q;
  logic [4:0]    rd_q;
  logic          ill_q, ov_q;

  logic [CW-1:0] d_len;
  logic [2:0]    d_cls;
  logic          d_ill;

  always_comb begin
    d_ill = 1'b0;
    d_cls = 3'd0;
    d_len = CW'(1);
    if (in_parcel[1:0] != 2'b11) begin
      d_ill = !allow_short;
    end else if (in_parcel[4:2] != 3'b111) begin
      d_cls = 3'd1;
      d_len = CW'(2);
    end else if (!in_parcel[5]) begin
      d_cls = 3'd2;
      d_len = CW'(3);
    end else if (!in_parcel[6]) begin
      d_cls = 3'd3;
      d_len = CW'(4);
    end else begin
      d_cls = 3'd4;
      d_len = CW'(5) + CW'(in_parcel[14:12]);
      d_ill = in_parcel[15];
    end
    if (d_ill) d_len = CW'(1);
  end

  assign in_ready    = !ov_q || out_ready;
  assign out_valid   = ov_q;
  assign out_insn    = ov_q ? buf_q : '0;
  assign out_parcels = need_q;
  assign out_class   = cls_q;
  assign out_rd      = rd_q;
  assign out_illegal = ill_q;

  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      need_q <= CW'(1);
      cls_q  <= '0;
      rd_q   <= '0;
      ill_q  <= 1'b0;
      ov_q   <= 1'b0;
    end else if (flush) begin
      cnt_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;
      if (take) begin
        if (cnt_q == '0) begin
          buf_q  <= {{(OW-PW){1'b0}}, in_parcel};
          need_q <= d_len;
          cls_q  <= d_cls;
          rd_q   <= (d_cls == 3'd4) ? in_parcel[11:7] : 5'd0;
          ill_q  <= d_ill;
          if (d_len == CW'(1)) ov_q  <= 1'b1;
          else                 cnt_q <= CW'(1);
        end else begin
          buf_q[cnt_q*PW +: PW] <= in_parcel;
          if (cnt_q + CW'(1) == need_q) begin
            ov_q  <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/parcel_aligner_chk.sv
module parcel_aligner_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [191:0] out_insn,
  input logic [3:0]   out_parcels,
  input logic [2:0]   out_class,
  input logic         out_illegal
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_insn) && $stable(out_parcels));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  assert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_parcels == 4'd1);

  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_parcels >= 4'd1 && out_parcels <= 4'd12);

  assert_zero_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_insn >> (32'(out_parcels) * 16)) == 192'd0);

  assert_short_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd0 |-> out_parcels == 4'd1);
endmodule

bind parcel_aligner parcel_aligner_chk chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
  .out_parcels(out_parcels), .out_class(out_class), .out_illegal(out_illegal)
);

// File: tb/parcel_aligner_tb_top.sv
module parcel_aligner_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, flush = 1'b0, allow_short = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] in_parcel = '0;
  logic in_ready, out_valid, out_illegal;
  logic [191:0] out_insn;
  logic [3:0] out_parcels;
  logic [2:0] out_class;
  logic [4:0] out_rd;

  parcel_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .allow_short(allow_short),
    .in_valid(in_valid), .in_parcel(in_parcel), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_parcels(out_parcels), .out_class(out_class), .out_rd(out_rd),
    .out_illegal(out_illegal)
  );

  typedef struct packed {
    logic [191:0] insn;
    logic [3:0]   np;
    logic [2:0]   cls;
    logic [4:0]   rd;
    logic         ill;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] pq[$];
  int n_cmp = 0, n_bad = 0;
  int ready_mode = 0;
  int vprob = 70;
  logic [191:0] held;
  bit held_v = 0;

  task automatic chk(bit ok, string req, string what, logic [191:0] act, logic [191:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [15:0] p0, bit short_ok);
    exp_t e;
    e = '0;
    e.insn = {176'd0, p0};
    e.np = 4'd1;
    if (p0[1:0] != 2'b11) begin
      e.cls = 3'd0; e.ill = !short_ok;
    end else if (p0[4:2] != 3'b111) begin
      e.cls = 3'd1; e.np = 4'd2;
    end else if (p0[5] == 1'b0) begin
      e.cls = 3'd2; e.np = 4'd3;
    end else if (p0[6] == 1'b0) begin
      e.cls = 3'd3; e.np = 4'd4;
    end else begin
      e.cls = 3'd4; e.rd = p0[11:7]; e.ill = p0[15];
      e.np = e.ill ? 4'd1 : 4'd5 + {1'b0, p0[14:12]};
    end
    return e;
  endfunction

  function automatic string tag(exp_t e);
    if (e.ill) return (e.cls == 3'd4) ? "R6" : "R7";
    case (e.cls)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic add_insn(int kind, bit bad, int n);
    logic [15:0] p0;
    exp_t e;
    p0 = 16'($urandom);
    case (kind)
      0: p0[1:0] = 2'($urandom_range(0, 2));
      1: begin p0[1:0] = 2'b11; p0[4:2] = 3'($urandom_range(0, 6)); end
      2: p0[5:0] = 6'b011111;
      3: p0[6:0] = 7'b0111111;
      default: begin
        p0[6:0] = 7'b1111111;
        p0[15] = bad;
        if (n >= 0) p0[14:12] = 3'(n);
      end
    endcase
    e = model(p0, allow_short);
    pq.push_back(p0);
    for (int i = 1; i < int'(e.np); i++) begin
      logic [15:0] q;
      q = 16'($urandom);
      pq.push_back(q);
      e.insn[i*16 +: 16] = q;
    end
    expq.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    in_valid  = (pq.size() > 0) && ($urandom_range(0, 99) < vprob);
    in_parcel = (pq.size() > 0) ? pq[0] : 16'($urandom);
    out_ready = (ready_mode == 0) ? ($urandom_range(0, 99) < 60) : (ready_mode == 1);
    #9;
    if (held_v) begin
      chk(out_valid && out_insn == held, "R9", "held output", out_insn, held);
      held_v = 0;
    end
    if (out_valid && !out_ready) begin
      chk(!in_ready, "R9", "in_ready while stalled", 192'(in_ready), 192'd0);
      held = out_insn;
      held_v = 1;
    end
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R10", "unexpected output", out_insn, 192'd0);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tag(e);
        chk(out_insn == e.insn, "R8", "insn", out_insn, e.insn);
        chk(out_parcels == e.np, t, "parcels", 192'(out_parcels), 192'(e.np));
        chk(out_class == e.cls, t, "class", 192'(out_class), 192'(e.cls));
        chk(out_rd == e.rd, "R5", "rd", 192'(out_rd), 192'(e.rd));
        chk(out_illegal == e.ill, t, "illegal", 192'(out_illegal), 192'(e.ill));
      end
    end
    if (in_valid && in_ready) void'(pq.pop_front());
  endtask

  task automatic drain(bit parcels_only);
    int guard = 0;
    while (pq.size() > 0 || (!parcels_only && (expq.size() > 0 || out_valid))) begin
      step();
      guard++;
      if (guard > 20000) begin
        chk(0, "WATCHDOG", "run did not drain", 192'(pq.size()), 192'd0);
        pq.delete();
        expq.delete();
        break;
      end
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    held_v = 0;
    chk(!out_valid, "R10", "out_valid after flush", 192'(out_valid), 192'd0);
    chk(in_ready, "R10", "in_ready after flush", 192'(in_ready), 192'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R11", "out_valid after reset", 192'(out_valid), 192'd0);
    chk(in_ready, "R11", "in_ready after reset", 192'(in_ready), 192'd1);

    ready_mode = 1; vprob = 100;
    for (int k = 0; k < 4; k++) add_insn(k, 0, -1);
    for (int n = 0; n < 8; n++) add_insn(4, 0, n);
    add_insn(4, 1, 7);
    add_insn(1, 0, -1);
    drain(0);

    ready_mode = 0; vprob = 70;
    for (int i = 0; i < 300; i++) add_insn($urandom_range(0, 4), $urandom_range(0, 9) == 0, -1);
    drain(0);

    allow_short = 1'b0;
    for (int i = 0; i < 40; i++) add_insn($urandom_range(0, 4), $urandom_range(0, 7) == 0, -1);
    drain(0);
    allow_short = 1'b1;

    pq.push_back(16'h307F);
    pq.push_back(16'h1234);
    pq.push_back(16'h5678);
    ready_mode = 1;
    drain(1);
    do_flush();
    add_insn(0, 0, -1);
    add_insn(2, 0, -1);
    drain(0);

    add_insn(0, 0, -1);
    expq.delete();
    ready_mode = 2;
    drain(1);
    repeat (2) step();
    do_flush();
    ready_mode = 1;
    repeat (4) step();
    add_insn(4, 0, 2);
    drain(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    n_cmp++;
    n_bad++;
    $display("FAIL WATCHDOG global timeout actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule